// File: doc/BRIEF.md
# Flash Erase Granularity Planner

This block turns an erase request, given as a starting sector number in 4 KB units and a number of sectors, into a series of erase commands for a serial flash sequencer. Each command carries an 8-bit opcode and a 24-bit byte address. At each step the planner uses the largest erase unit that starts on an aligned boundary and lies entirely inside the part of the range still to be erased. The unit is 64 KB, 32 KB or 4 KB. Compared with one 4 KB erase per sector, this cuts the number of commands sharply.

A request is accepted on a valid/ready handshake. Commands then leave one at a time through a second valid/ready handshake towards the sequencer. After the sequencer accepts the command that finishes the range, the block raises a single-cycle completion pulse and becomes ready for the next request. Sending the commands over the serial bus is the sequencer's job.

Top module: `erase_planner`

## Requirements
- R1: During and right after reset, `cmd_valid` and `done` are 0 and `start_ready` is 1.
- R2: If the current sector number is a multiple of 16 and at least 16 sectors remain, the command has opcode 0xD8 and the planner then advances 16 sectors.
- R3: Otherwise, if the current sector is a multiple of 8 and at least 8 sectors remain, the command has opcode 0x52 and the planner advances 8 sectors.
- R4: In every other case the command has opcode 0x20 and the planner advances one sector.
- R5: The 64 KB test is applied again on every step. Once smaller erases have brought the current sector to a multiple of 16 with 16 or more sectors left, the next command is 0xD8 again.
- R6: `cmd_addr` equals the current sector number shifted left by 12, so bits 11:0 are zero.
- R7: A request with a count of zero produces no command. `done` is high in the cycle after the request handshake, and `start_ready` is high again.
- R8: While a request is in progress, `start_ready` is 0 and a `start_valid` pulse has no effect. The running command sequence continues unchanged, and no further command appears after `done`.
- R9: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid`, `cmd_opcode` and `cmd_addr` hold their values into the next cycle.
- R10: `done` is high for exactly one cycle, namely the cycle after the last command is accepted. In that cycle `cmd_valid` is 0. The commands accepted before it cover exactly the requested sectors, in order and without gaps.
- R11: For a nonzero count, the first command is valid in the cycle after the request handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_valid | input | 1 | Request offered |
| start_ready | output | 1 | Planner idle; a request is accepted when both are high |
| start_sector | input | 12 | First sector of the range, in 4 KB units |
| start_count | input | 12 | Number of sectors to erase |
| cmd_valid | output | 1 | Erase command offered to the sequencer |
| cmd_ready | input | 1 | Sequencer takes the command when both are high |
| cmd_opcode | output | 8 | Erase opcode: 0xD8 (64 KB), 0x52 (32 KB), 0x20 (4 KB) |
| cmd_addr | output | 24 | Byte address of the erase unit |
| done | output | 1 | One-cycle pulse when the request is finished |

## Verification
The bench sweeps start sectors and counts that cross several 64 KB boundaries. This hits the ranges where a design that tested 32 KB before 64 KB, or checked alignment without checking the remaining count, would emit an oversized erase past the range end, or would never return to 64 KB erases after a run of small ones. Zero counts are covered, so that a design emitting one stray 4 KB erase for an empty request is exposed. The sequencer is stalled in pseudo-random patterns, which catches command fields that change while waiting and a completion pulse that arrives one cycle late or early. Requests presented while busy check that a design re-capturing its inputs would derail the running sequence.

// File: rtl/erase_plan_pkg.sv
package erase_plan_pkg;

    // Erase units, largest first; the index order is the test priority.
    localparam int N_UNITS = 3;

    typedef enum logic [0:0] {
        PL_IDLE = 1'b0,
        PL_RUN  = 1'b1
    } plan_state_e;

    // log2 of the unit size expressed in 4 KB sectors
    function automatic int unsigned unit_shift(input int unsigned idx);
        case (idx)
            0:       return 4;   // 64 KB
            1:       return 3;   // 32 KB
            default: return 0;   // 4 KB
        endcase
    endfunction

    function automatic logic [7:0] unit_opcode(input int unsigned idx);
        case (idx)
            0:       return 8'hD8;
            1:       return 8'h52;
            default: return 8'h20;
        endcase
    endfunction

endpackage

// File: rtl/erase_unit_pick.sv
module erase_unit_pick
    import erase_plan_pkg::*;
#(
    parameter int SECT_W = 12,
    parameter int CNT_W  = 12
) (
    input  logic [SECT_W-1:0] sector,
    input  logic [CNT_W-1:0]  remain,
    output logic [7:0]        opcode,
    output logic [CNT_W-1:0]  span
);

    logic [N_UNITS-1:0] fits;

    // One alignment/coverage test per erase unit
    for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
        localparam int unsigned SH = unit_shift(i);
        localparam logic [CNT_W-1:0]  SIZE = CNT_W'(1) << SH;
        localparam logic [SECT_W-1:0] MASK = (SECT_W'(1) << SH) - SECT_W'(1);
        assign fits[i] = ((sector & MASK) == '0) && (remain >= SIZE);
    end

    // Priority: lowest index (largest unit) that fits wins
    always_comb begin
        opcode = unit_opcode(N_UNITS - 1);
        span   = CNT_W'(1) << unit_shift(N_UNITS - 1);
        for (int i = N_UNITS - 1; i >= 0; i--) begin
            if (fits[i]) begin
                opcode = unit_opcode(i);
                span   = CNT_W'(1) << unit_shift(i);
            end
        end
    end

endmodule

// File: rtl/erase_planner.sv
module erase_planner
    import erase_plan_pkg::*;
#(
    parameter int SECT_W     = 12,
    parameter int CNT_W      = 12,
    parameter int SECT_SHIFT = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_valid,
    output logic                         start_ready,
    input  logic [SECT_W-1:0]            start_sector,
    input  logic [CNT_W-1:0]             start_count,
    output logic                         cmd_valid,
    input  logic                         cmd_ready,
    output logic [7:0]                   cmd_opcode,
    output logic [SECT_W+SECT_SHIFT-1:0] cmd_addr,
    output logic                         done
);

    localparam int ADDR_W = SECT_W + SECT_SHIFT;
    localparam logic [ADDR_W-1:0] MASK_64K = (ADDR_W'(1) << (SECT_SHIFT + 4)) - ADDR_W'(1);
    localparam logic [ADDR_W-1:0] MASK_32K = (ADDR_W'(1) << (SECT_SHIFT + 3)) - ADDR_W'(1);

    typedef struct packed {
        plan_state_e       state;
        logic [SECT_W-1:0] sector;   // sector of the command on offer
        logic [CNT_W-1:0]  remain;   // sectors left, including the offered one
        logic [7:0]        op;
        logic [CNT_W-1:0]  step;
        logic              done;
    } plan_regs_t;

    plan_regs_t q, d;

    logic [SECT_W-1:0] nxt_sector;
    logic [CNT_W-1:0]  nxt_remain;
    logic [7:0]        pick_op;
    logic [CNT_W-1:0]  pick_span;
    logic              accept_req;
    logic              accept_cmd;

    assign accept_req = (q.state == PL_IDLE) && start_valid;
    assign accept_cmd = (q.state == PL_RUN) && cmd_ready;

    // Position the planner would move to this cycle
    always_comb begin
        nxt_sector = q.sector;
        nxt_remain = q.remain;
        if (accept_req) begin
            nxt_sector = start_sector;
            nxt_remain = start_count;
        end else if (accept_cmd) begin
            nxt_sector = q.sector + SECT_W'(q.step);
            nxt_remain = q.remain - q.step;
        end
    end

    erase_unit_pick #(
        .SECT_W (SECT_W),
        .CNT_W  (CNT_W)
    ) u_pick (
        .sector (nxt_sector),
        .remain (nxt_remain),
        .opcode (pick_op),
        .span   (pick_span)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (accept_req || accept_cmd) begin
            d.sector = nxt_sector;
            d.remain = nxt_remain;
            if (nxt_remain == '0) begin
                d.state = PL_IDLE;
                d.done  = 1'b1;
            end else begin
                d.state = PL_RUN;
                d.op    = pick_op;
                d.step  = pick_span;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: PL_IDLE, sector: '0, remain: '0, op: 8'h00, step: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign start_ready = (q.state == PL_IDLE);
    assign cmd_valid   = (q.state == PL_RUN);
    assign cmd_opcode  = q.op;
    assign cmd_addr    = {q.sector, {SECT_SHIFT{1'b0}}};
    assign done        = q.done;

    // ---------------- assertions ----------------
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_opcode) && $stable(cmd_addr));

    p_big_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_opcode == 8'hD8 |-> (cmd_addr & MASK_64K) == '0);

    p_mid_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_opcode == 8'h52 |-> (cmd_addr & MASK_32K) == '0);

    p_known_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_opcode inside {8'hD8, 8'h52, 8'h20});

    p_busy_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !start_ready);

    p_zero_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid && start_ready && start_count == '0 |=> done && !cmd_valid);

    p_launch_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid && start_ready && start_count != '0 |=> cmd_valid);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_valid && start_ready && !$past(done));

endmodule

// File: tb/erase_planner_test.sv
module erase_planner_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_valid;
    logic        start_ready;
    logic [11:0] start_sector;
    logic [11:0] start_count;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [7:0]  cmd_opcode;
    logic [23:0] cmd_addr;
    logic        done;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;   // 50 MHz

    erase_planner uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_valid  (start_valid),
        .start_ready  (start_ready),
        .start_sector (start_sector),
        .start_count  (start_count),
        .cmd_valid    (cmd_valid),
        .cmd_ready    (cmd_ready),
        .cmd_opcode   (cmd_opcode),
        .cmd_addr     (cmd_addr),
        .done         (done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected unit from the greedy rules
    task automatic exp_pick(input logic [11:0] s, input int rem, output logic [7:0] op, output int st);
        if (s % 16 == 0 && rem >= 16) begin
            op = 8'hD8; st = 16;
        end else if (s % 8 == 0 && rem >= 8) begin
            op = 8'h52; st = 8;
        end else begin
            op = 8'h20; st = 1;
        end
    endtask

    task automatic run_op(input int sec, input int cnt, input int mode);
        logic [11:0] es;
        int er;
        logic [7:0] eop;
        int est;
        bit r;
        string tag;
        chk(start_ready == 1'b1, "R1 idle before request", 32'(start_ready), 32'h1);
        start_valid  = 1'b1;
        start_sector = 12'(sec);
        start_count  = 12'(cnt);
        @(posedge clk);
        @(negedge clk);
        start_valid = 1'b0;
        if (cnt == 0) begin
            chk(done && !cmd_valid, "R7 zero count", {cmd_valid, done}, 32'h1);
            @(negedge clk);
            chk(!done && !cmd_valid && start_ready, "R7 after zero count",
                {start_ready, cmd_valid, done}, 32'h4);
            return;
        end
        chk(cmd_valid == 1'b1, "R11 first command", 32'(cmd_valid), 32'h1);
        es = 12'(sec);
        er = cnt;
        while (er > 0) begin
            exp_pick(es, er, eop, est);
            if (eop == 8'hD8) tag = (es != 12'(sec)) ? "R5 return to 64K" : "R2 64K erase";
            else if (eop == 8'h52) tag = "R3 32K erase";
            else tag = "R4 4K erase";
            chk(cmd_valid && cmd_opcode == eop, tag, {23'h0, cmd_valid, cmd_opcode}, {24'h1, eop});
            chk(cmd_addr == {es, 12'h000}, "R6 address", 32'(cmd_addr), 32'({es, 12'h000}));
            chk(!start_ready && !done, "R8 busy", {start_ready, done}, 32'h0);
            r = (mode == 0) ? 1'b1 : lfsr[0];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cmd_ready = r;
            if (!r && mode == 2) begin
                start_valid  = 1'b1;
                start_sector = 12'(sec + 5);
                start_count  = 12'd1;
            end
            @(posedge clk);
            @(negedge clk);
            start_valid = 1'b0;
            if (r) begin
                es = es + 12'(est);
                er = er - est;
            end else begin
                chk(cmd_valid && cmd_opcode == eop && cmd_addr == {es, 12'h000}, "R9 hold while stalled",
                    {cmd_opcode, cmd_addr}, {eop, es, 12'h000});
            end
        end
        cmd_ready = 1'b0;
        chk(done && !cmd_valid, "R10 done after last accept", {cmd_valid, done}, 32'h1);
        @(negedge clk);
        chk(!done && !cmd_valid && start_ready, "R10 single pulse",
            {start_ready, cmd_valid, done}, 32'h4);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                bad++;
                total++;
                $display("FAIL watchdog act=%0d exp=finished", cycles);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        rst_n        = 1'b0;
        start_valid  = 1'b0;
        start_sector = '0;
        start_count  = '0;
        cmd_ready    = 1'b0;
        repeat (3) @(negedge clk);
        chk(!cmd_valid && !done && start_ready, "R1 reset state",
            {start_ready, cmd_valid, done}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cmd_valid && !done && start_ready, "R1 after reset",
            {start_ready, cmd_valid, done}, 32'h4);
        for (int s = 0; s < 48; s++) begin
            for (int c = 0; c <= 40; c++) begin
                run_op(s, c, (s + c) % 3);
            end
        end
        // Larger ranges near the top of the sector space
        run_op(4000, 90, 1);
        run_op(4064, 32, 2);
        run_op(7, 70, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule